// File: doc/BRIEF.md
# External Reset Handshake Interlock

This block sits between a power sequencer's reset-wait step and the reset of the surrounding platform. Several internal reset sources (software, debugger, escalation and similar) each come with an enable bit. The enabled requests are combined into a single request, and that request is driven off-chip so the platform can assert its own reset. Each internal request is also recorded in a sticky flag. The flag keeps the sequencer from leaving its reset-wait step until the platform has asserted its reset and then released it again.

The platform's reset line arrives asynchronously. A two-stage synchronizer samples it first. A stability filter then passes it on only after the line has held one value for four consecutive clock cycles. The filtered line is exported without any mask. The synchronizer, the filter and the flag all run on the always-on clock and are cleared only by power-on reset. As a result, the platform reset being observed can never reset the logic that is observing it.

The sticky flag is a two-state machine. `ILK_CLEAR` means no request is outstanding. `ILK_HELD` means a request is waiting for the platform to finish a reset. There are two transitions:
- **arm** (`ILK_CLEAR` to `ILK_HELD`) is taken when the combined internal request is high.
- **release** (`ILK_HELD` to `ILK_CLEAR`) is taken on a falling edge of the filtered platform reset.

While the flag is in `ILK_HELD`, the proceed output stays low with no time limit.

Top module: `ext_rst_interlock`

## Requirements
- R1: `plat_rst_req_o` is high exactly when some bit i has both `src_req_i[i]` and `src_en_i[i]` high. A request whose enable bit is 0 has no effect on the output. The output is combinational.
- R2: `ext_rst_req_o` follows `ext_rst_async_i` with no mask. After the input changes (driven between clock edges), the output takes the new value on the 6th rising clock edge: two synchronizer edges followed by four matching filter samples. The output is unchanged after the 5th edge.
- R3: A level on `ext_rst_async_i` that lasts fewer than 4 clock cycles never reaches `ext_rst_req_o`. A level that lasts 4 cycles does reach it.
- R4: `sticky_o` goes high on the clock edge that follows a cycle with `plat_rst_req_o` high.
- R5: Once `sticky_o` is high, it stays high until `ext_rst_req_o` falls. A rise of `ext_rst_req_o` does not clear it. `sticky_o` goes low one clock edge after `ext_rst_req_o` falls.
- R6: If an internal request and the release edge occur in the same cycle, release wins and `sticky_o` goes low. If the request is still held, `sticky_o` returns high on the following edge.
- R7: `proceed_o` is high exactly when `reset_valid_i` is high, `main_pwr_req_i` is low and `sticky_o` is low. It stays low indefinitely while `sticky_o` is high, even if the platform line never toggles.
- R8: While `por_n` is low, `sticky_o` and `ext_rst_req_o` are 0, including in the middle of a run with the platform line high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_aon | input | 1 | Always-on clock |
| por_n | input | 1 | Power-on reset, active low, the only reset of the block |
| src_req_i | input | NUM_SRC | Per-source internal reset requests |
| src_en_i | input | NUM_SRC | Per-source enable mask |
| ext_rst_async_i | input | 1 | Asynchronous platform reset indication |
| reset_valid_i | input | 1 | Sequencer reports that the reset has been applied |
| main_pwr_req_i | input | 1 | Main-power reset request still pending |
| plat_rst_req_o | output | 1 | Combined internal request sent to the platform |
| proceed_o | output | 1 | Reset-wait step may advance |
| sticky_o | output | 1 | Sticky request flag status |
| ext_rst_req_o | output | 1 | Synchronized, filtered platform reset |

## Verification
The bench targets the corner cases that decide whether the interlock releases at the right moment:
- **Filter timing.** It checks the exact edge at which the filtered line rises and falls, and it sends a three-cycle glitch that must vanish. A filter that counted one sample too few would let the glitch through and release early.
- **Rise versus fall.** It checks that a rising platform reset leaves the flag set. A design that cleared on either edge would let the sequencer run while the platform is still in reset.
- **Release against a held request.** It drives a request that is still held on the release edge and expects one low cycle followed by re-arming. A design that gave set priority would never show that low cycle.
- **Long hold and mid-run reset.** It holds the flag for a long stretch and applies power-on reset mid-run, checking that nothing leaks out of the hold or survives the reset.

// File: rtl/ext_rst_ilk_pkg.sv
package ext_rst_ilk_pkg;

    typedef enum logic {
        ILK_CLEAR = 1'b0,
        ILK_HELD  = 1'b1
    } ilk_state_e;

    localparam int unsigned DEF_NUM_SRC     = 4;
    localparam int unsigned DEF_SYNC_STAGES = 2;
    localparam int unsigned DEF_FILT_CYCLES = 4;

endpackage

// File: rtl/ext_rst_sync.sv
module ext_rst_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge por_n) begin
                if (!por_n) chain_q <= '0;
                else        chain_q <= async_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge por_n) begin
                if (!por_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], async_i};
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/ext_rst_filter.sv
module ext_rst_filter #(
    parameter int unsigned CYCLES = 4
) (
    input  logic clk,
    input  logic por_n,
    input  logic raw_i,
    output logic filt_o
);
    localparam int unsigned CW = $clog2(CYCLES + 1);

    logic          prev_q;
    logic [CW-1:0] run_q;
    logic          filt_q;
    logic          same;

    assign same = (raw_i == prev_q);

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            prev_q <= 1'b0;
            run_q  <= '0;
            filt_q <= 1'b0;
        end else begin
            if (!same) begin
                prev_q <= raw_i;
                run_q  <= CW'(1);
            end else if (run_q < CW'(CYCLES)) begin
                run_q  <= run_q + CW'(1);
            end
            if (same && (run_q >= CW'(CYCLES - 1))) begin
                filt_q <= raw_i;
            end
        end
    end

    assign filt_o = filt_q;

    AST_FILT_NEEDS_RUN: assert property (@(posedge clk) disable iff (!por_n)
        !$stable(filt_q) |-> ($past(run_q) >= CW'(CYCLES - 1))); // R3

    AST_FILT_TAKES_SAMPLE: assert property (@(posedge clk) disable iff (!por_n)
        !$stable(filt_q) |-> (filt_q == $past(raw_i))); // R2
endmodule

// File: rtl/ext_rst_gather.sv
module ext_rst_gather #(
    parameter int unsigned NUM_SRC = 4
) (
    input  logic [NUM_SRC-1:0] req_i,
    input  logic [NUM_SRC-1:0] en_i,
    output logic               req_o
);
    logic [NUM_SRC-1:0] gated;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_SRC; gi++) begin : g_gate
            assign gated[gi] = req_i[gi] & en_i[gi];
        end
    endgenerate

    assign req_o = |gated;

    always_comb begin
        AST_GATHER_MASKED: assert (!(req_o && ((req_i & en_i) == '0))); // R1
    end
endmodule

// File: rtl/ext_rst_sticky.sv
module ext_rst_sticky
    import ext_rst_ilk_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic int_req_i,
    input  logic ext_filt_i,
    output logic sticky_o
);
    ilk_state_e state_q, state_d;
    logic       ext_q;
    logic       fall;

    assign fall = ext_q & ~ext_filt_i;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= ILK_CLEAR;
            ext_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            ext_q   <= ext_filt_i;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ILK_CLEAR: if (int_req_i) state_d = ILK_HELD;
            ILK_HELD:  if (fall)      state_d = ILK_CLEAR;
            default:   state_d = ILK_CLEAR;
        endcase
    end

    always_comb begin
        sticky_o = 1'b0;
        unique case (state_q)
            ILK_CLEAR: sticky_o = 1'b0;
            ILK_HELD:  sticky_o = 1'b1;
            default:   sticky_o = 1'b0;
        endcase
    end

    AST_STICKY_ARMS: assert property (@(posedge clk) disable iff (!por_n)
        (int_req_i && !(sticky_o && fall)) |=> sticky_o); // R4

    AST_STICKY_KEEPS: assert property (@(posedge clk) disable iff (!por_n)
        (sticky_o && !fall) |=> sticky_o); // R5

    AST_RELEASE_WINS: assert property (@(posedge clk) disable iff (!por_n)
        (sticky_o && fall) |=> !sticky_o); // R6
endmodule

// File: rtl/ext_rst_interlock.sv
module ext_rst_interlock
    import ext_rst_ilk_pkg::*;
#(
    parameter int unsigned NUM_SRC     = DEF_NUM_SRC,
    parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES,
    parameter int unsigned FILT_CYCLES = DEF_FILT_CYCLES
) (
    input  logic               clk_aon,
    input  logic               por_n,
    input  logic [NUM_SRC-1:0] src_req_i,
    input  logic [NUM_SRC-1:0] src_en_i,
    input  logic               ext_rst_async_i,
    input  logic               reset_valid_i,
    input  logic               main_pwr_req_i,
    output logic               plat_rst_req_o,
    output logic               proceed_o,
    output logic               sticky_o,
    output logic               ext_rst_req_o
);
    logic int_req;
    logic ext_synced;
    logic ext_filt;
    logic held;

    ext_rst_gather #(.NUM_SRC(NUM_SRC)) u_gather (
        .req_i (src_req_i),
        .en_i  (src_en_i),
        .req_o (int_req)
    );

    ext_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk_aon),
        .por_n   (por_n),
        .async_i (ext_rst_async_i),
        .sync_o  (ext_synced)
    );

    ext_rst_filter #(.CYCLES(FILT_CYCLES)) u_filter (
        .clk    (clk_aon),
        .por_n  (por_n),
        .raw_i  (ext_synced),
        .filt_o (ext_filt)
    );

    ext_rst_sticky u_sticky (
        .clk        (clk_aon),
        .por_n      (por_n),
        .int_req_i  (int_req),
        .ext_filt_i (ext_filt),
        .sticky_o   (held)
    );

    assign plat_rst_req_o = int_req;
    assign ext_rst_req_o  = ext_filt;
    assign sticky_o       = held;
    assign proceed_o      = reset_valid_i & ~main_pwr_req_i & ~held;

    AST_NO_PROCEED_WHILE_HELD: assert property (@(posedge clk_aon) disable iff (!por_n)
        sticky_o |-> !proceed_o); // R7

    AST_PROCEED_NEEDS_VALID: assert property (@(posedge clk_aon) disable iff (!por_n)
        proceed_o |-> (reset_valid_i && !main_pwr_req_i)); // R7
endmodule

// File: tb/tb_ext_rst_interlock.sv
module tb_ext_rst_interlock;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 4;

    logic clk_aon = 1'b0;
    logic por_n = 1'b0;
    logic [NS-1:0] src_req_i = '0;
    logic [NS-1:0] src_en_i = '0;
    logic ext_rst_async_i = 1'b0;
    logic reset_valid_i = 1'b0;
    logic main_pwr_req_i = 1'b0;
    logic plat_rst_req_o, proceed_o, sticky_o, ext_rst_req_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk_aon = ~clk_aon;

    ext_rst_interlock #(.NUM_SRC(NS)) dut (
        .clk_aon, .por_n, .src_req_i, .src_en_i, .ext_rst_async_i,
        .reset_valid_i, .main_pwr_req_i,
        .plat_rst_req_o, .proceed_o, .sticky_o, .ext_rst_req_o
    );

    // [12:9] req, [8:5] en, [4] valid, [3] main req, [2] exp plat, [1] exp proceed, [0] exp sticky
    localparam logic [12:0] VEC [9] = '{
        13'b0000_1111_1_0_0_1_0,
        13'b0101_1010_1_0_0_1_0,
        13'b1111_0000_1_1_0_0_0,
        13'b0000_1111_0_0_0_0_0,
        13'b1010_0101_1_0_0_1_0,
        13'b0001_0001_1_0_1_1_0,
        13'b0000_1111_1_0_0_0_1,
        13'b1000_1000_1_0_1_0_1,
        13'b0000_0000_1_0_0_0_1
    };

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary_and_end();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk_aon);
        errors++;
        $display("FAIL watchdog expired");
        summary_and_end();
    end

    initial begin
        logic seen;
        // R8: reset state
        repeat (3) @(negedge clk_aon);
        chk("R8 sticky in reset", sticky_o, 1'b0);
        chk("R8 ext in reset", ext_rst_req_o, 1'b0);
        chk("R1 plat in reset", plat_rst_req_o, 1'b0);
        por_n = 1'b1;
        repeat (8) @(negedge clk_aon);

        // R1 R4 R7: vector walk
        for (int i = 0; i < 9; i++) begin
            @(negedge clk_aon);
            src_req_i      = VEC[i][12:9];
            src_en_i       = VEC[i][8:5];
            reset_valid_i  = VEC[i][4];
            main_pwr_req_i = VEC[i][3];
            #1;
            chk($sformatf("R1 plat vec%0d", i), plat_rst_req_o, VEC[i][2]);
            chk($sformatf("R7 proceed vec%0d", i), proceed_o, VEC[i][1]);
            chk($sformatf("R4 sticky vec%0d", i), sticky_o, VEC[i][0]);
        end

        // R7: indefinite hold with no platform activity
        repeat (40) @(negedge clk_aon);
        chk("R7 still held", sticky_o, 1'b1);
        chk("R7 proceed low", proceed_o, 1'b0);

        // R2 R5: platform asserts, then releases
        ext_rst_async_i = 1'b1;
        repeat (5) @(posedge clk_aon); #1;
        chk("R2 rise not before 6th edge", ext_rst_req_o, 1'b0);
        @(posedge clk_aon); #1;
        chk("R2 rise on 6th edge", ext_rst_req_o, 1'b1);
        chk("R5 rise keeps sticky", sticky_o, 1'b1);
        repeat (3) @(negedge clk_aon);
        ext_rst_async_i = 1'b0;
        repeat (5) @(posedge clk_aon); #1;
        chk("R2 fall not before 6th edge", ext_rst_req_o, 1'b1);
        @(posedge clk_aon); #1;
        chk("R2 fall on 6th edge", ext_rst_req_o, 1'b0);
        chk("R5 sticky one edge after fall", sticky_o, 1'b1);
        @(posedge clk_aon); #1;
        chk("R5 sticky cleared", sticky_o, 1'b0);
        chk("R7 proceed after release", proceed_o, 1'b1);

        // R3: 3-cycle glitch blocked
        @(negedge clk_aon);
        ext_rst_async_i = 1'b1;
        repeat (3) @(negedge clk_aon);
        ext_rst_async_i = 1'b0;
        seen = 1'b0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk_aon);
            if (ext_rst_req_o) seen = 1'b1;
        end
        chk("R3 short glitch blocked", seen, 1'b0);

        // R3: 4-cycle level passes
        ext_rst_async_i = 1'b1;
        repeat (4) @(negedge clk_aon);
        ext_rst_async_i = 1'b0;
        seen = 1'b0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk_aon);
            if (ext_rst_req_o) seen = 1'b1;
        end
        chk("R3 four-cycle level passes", seen, 1'b1);
        repeat (8) @(negedge clk_aon);

        // R6: release versus held request
        src_req_i = 4'b0001;
        src_en_i  = 4'b0001;
        ext_rst_async_i = 1'b1;
        repeat (10) @(negedge clk_aon);
        chk("R6 armed", sticky_o, 1'b1);
        ext_rst_async_i = 1'b0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk_aon);
            if (!ext_rst_req_o) break;
        end
        chk("R6 sticky at fall", sticky_o, 1'b1);
        @(negedge clk_aon);
        chk("R6 release wins", sticky_o, 1'b0);
        @(negedge clk_aon);
        chk("R6 rearmed", sticky_o, 1'b1);

        // R8: power-on reset mid-run
        ext_rst_async_i = 1'b1;
        repeat (10) @(negedge clk_aon);
        src_req_i = '0;
        por_n = 1'b0;
        #1;
        chk("R8 sticky cleared by por", sticky_o, 1'b0);
        chk("R8 ext cleared by por", ext_rst_req_o, 1'b0);
        repeat (2) @(negedge clk_aon);
        por_n = 1'b1;
        @(negedge clk_aon);
        chk("R7 proceed after por", proceed_o, 1'b1);
        ext_rst_async_i = 1'b0;
        repeat (4) @(negedge clk_aon);

        summary_and_end();
    end
endmodule